// File: doc/BRIEF.md
# Serial Dual-DAC Command Receiver

This block is the digital front end of a two-channel 12-bit converter that is programmed over a three-wire serial link. The link has a serial clock, a data line and an active-low frame select. Driving the frame select low opens a frame. The next 16 falling edges of the serial clock then shift in one command word, most significant bit first. The first four bits of the word are control bits: a channel select, a reference-buffer enable and a two-bit power mode. The last twelve bits are the converter code.

Each channel holds an input register and a converter register. A complete frame always writes the input register of the addressed channel. It also writes that channel's buffer and power-mode controls. The frame then reaches the converter register in one of two ways. If the load input is low when the frame completes, it goes through at once. If the load input is high, the frame stays in the input register. A rising edge on the load input then copies both input registers into both converter registers in the same clock cycle, so the two outputs change together.

All serial and load pins are asynchronous to the block clock. They are resynchronised and oversampled, which assumes that the block clock is several times faster than the serial clock.

Top module: `dac_serial_rx`

## Requirements
- R1: While reset is asserted, and after reset until a valid frame completes, both converter codes, both buffer enables and both power modes read zero.
- R2: A falling edge on `sync_n` starts a frame. Each following falling edge of `sclk` captures `din`, and the first captured bit is word bit 15.
- R3: Word bit 15 selects the channel (0 = A, 1 = B). A frame changes only the registers of the channel it addresses.
- R4: Word bit 14 is written to `buf_en` of the addressed channel when the frame completes (1 = buffered reference), whatever the level of `ld`.
- R5: Word bits 13:12 are written to the addressed channel's power mode when the frame completes, whatever the level of `ld`. The encoding is 00 normal, 01 power-down with 1 kOhm to ground, 10 power-down with 100 kOhm to ground, 11 power-down with high-impedance output.
- R6: If `ld` is low when the 16th bit is captured, the addressed channel's converter code takes word bits 11:0.
- R7: If `ld` is high when the 16th bit is captured, only the input register is written. Both converter codes keep their values.
- R8: A rising edge of `ld` copies both input registers into both converter codes in the same clock cycle.
- R9: If `sync_n` rises before 16 bits have been captured, the frame is discarded and no output changes. The next falling edge of `sync_n` starts a new frame from bit 15.
- R10: Falling edges of `sclk` after the 16th, while `sync_n` stays low, are ignored. They do not cause a second update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than sclk |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, data captured on falling edge |
| din | input | 1 | Serial data, most significant bit first |
| sync_n | input | 1 | Active-low frame select |
| ld | input | 1 | Load: low = immediate update, rising edge = update both channels |
| dac_a | output | DATA_W | Channel A converter code |
| dac_b | output | DATA_W | Channel B converter code |
| buf_en | output | 2 | Reference-buffer enable, bit 0 = A, bit 1 = B |
| pmode_a | output | 2 | Channel A power mode |
| pmode_b | output | 2 | Channel B power mode |

## Verification
The bench sends every combination of the four control bits, each with all-zero, all-one and mixed codes. A decoder that swapped control fields or shifted in the wrong order would show a wrong code or mode on a channel. A channel-select fault would show up as a change on the channel that was not addressed. Frames cut short by an early `sync_n` rise must leave every output unchanged; a receiver that committed partial words or kept a stale bit count would corrupt the next frame. Extra clock edges after the 16th bit would re-commit a shifted word on a receiver that keeps counting. Frames written while `ld` is high must leave both codes unchanged until the rising edge, and that edge must move both channels at once.

// File: rtl/dacrx_pkg.sv
// Shared definitions for the serial dual-DAC command receiver.
// Assumes a fixed pair of channels and a four-bit control header.
package dacrx_pkg;
    localparam int NCH    = 2;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PD_1K   = 2'b01,
        PM_PD_100K = 2'b10,
        PM_PD_HIZ  = 2'b11
    } pmode_t;
endpackage

// File: rtl/dacrx_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes every bit is an independent level; all bits see equal latency.
module dacrx_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dacrx_shifter.sv
// Frame shifter: opens on a falling frame select, captures one bit per
// falling serial clock edge, and pulses frm_valid for one cycle with the
// whole word on the edge that captures the last bit. An early rise of the
// frame select discards the frame. Extra edges after the last bit are
// ignored. Inputs must already be synchronised to clk.
module dacrx_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               din_s,
    input  logic               sync_n_s,
    output logic               frm_valid,
    output logic [FRAME_W-1:0] frm_word
);
    localparam int               CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);

    logic               sclk_q;
    logic               sync_q;
    logic               active;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-2:0] shreg;
    logic               sclk_fall;
    logic               sync_fall;

    assign sclk_fall = sclk_q & ~sclk_s;
    assign sync_fall = sync_q & ~sync_n_s;

    // Remember the previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sync_q <= sync_n_s;
        end
    end

    // Track frame progress: open, count bits, close on completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else if (sync_fall) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (sync_n_s) begin
            active <= 1'b0;
        end else if (active && sclk_fall) begin
            shreg <= {shreg[FRAME_W-3:0], din_s};
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end

    assign frm_valid = active && sclk_fall && !sync_n_s && (cnt == LAST);
    assign frm_word  = {shreg, din_s};
endmodule

// File: rtl/dacrx_chan.sv
// One converter channel: input register, converter register and controls.
// A write always loads the input register and the controls. The converter
// register follows immediately when the load level is low, and takes the
// freshly written input value on a load pulse, even a pulse in the same
// cycle as a write.
module dacrx_chan
    import dacrx_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_buf,
    input  logic [1:0]        wr_pm,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_level,
    input  logic              ld_pulse,
    output logic [DATA_W-1:0] dac_code,
    output logic              buf_en,
    output logic [1:0]        pmode
);
    logic [DATA_W-1:0] inp_q;
    logic [DATA_W-1:0] inp_next;
    logic [DATA_W-1:0] dac_q;
    logic              buf_q;
    pmode_t            pm_q;

    // Value the input register will hold after this cycle.
    always_comb inp_next = wr ? wr_data : inp_q;

    // Update the input register, the converter register and the controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inp_q <= '0;
            dac_q <= '0;
            buf_q <= 1'b0;
            pm_q  <= PM_NORMAL;
        end else begin
            inp_q <= inp_next;
            if (ld_pulse)             dac_q <= inp_next;
            else if (wr && !ld_level) dac_q <= wr_data;
            if (wr) begin
                buf_q <= wr_buf;
                pm_q  <= pmode_t'(wr_pm);
            end
        end
    end

    assign dac_code = dac_q;
    assign buf_en   = buf_q;
    assign pmode    = pm_q;
endmodule

// File: rtl/dac_serial_rx.sv
// Serial dual-DAC command receiver top. Synchronises the serial and load
// pins, frames 16-bit commands, and routes each command to the addressed
// channel slice. Detects the load rising edge for the two-channel update.
// Assumes clk is at least about four times faster than sclk.
module dac_serial_rx
    import dacrx_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              sync_n,
    input  logic              ld,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic [1:0]        buf_en,
    output logic [1:0]        pmode_a,
    output logic [1:0]        pmode_b
);
    localparam int FRAME_W = CTRL_W + DATA_W;
    localparam int SEL_BIT = FRAME_W - 1;
    localparam int BUF_BIT = FRAME_W - 2;
    localparam int PM_HI   = FRAME_W - 3;
    localparam int PM_LO   = FRAME_W - 4;

    logic [3:0]         pins_s;
    logic               sclk_s, din_s, sync_n_s, ld_s;
    logic               ld_q;
    logic               ld_pulse;
    logic               frm_valid;
    logic [FRAME_W-1:0] frm_word;
    logic [DATA_W-1:0]  code [NCH];
    logic [1:0]         pm   [NCH];

    dacrx_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0101)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ld, sync_n, din, sclk}),
        .q     (pins_s)
    );

    assign {ld_s, sync_n_s, din_s, sclk_s} = pins_s;

    // Previous load level, for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= ld_s;
    end

    assign ld_pulse = ld_s & ~ld_q;

    dacrx_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .sync_n_s  (sync_n_s),
        .frm_valid (frm_valid),
        .frm_word  (frm_word)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic wr_sel;
        assign wr_sel = frm_valid && (frm_word[SEL_BIT] == 1'(ch));

        dacrx_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_sel),
            .wr_buf   (frm_word[BUF_BIT]),
            .wr_pm    (frm_word[PM_HI:PM_LO]),
            .wr_data  (frm_word[DATA_W-1:0]),
            .ld_level (ld_s),
            .ld_pulse (ld_pulse),
            .dac_code (code[ch]),
            .buf_en   (buf_en[ch]),
            .pmode    (pm[ch])
        );
    end

    assign dac_a   = code[0];
    assign dac_b   = code[1];
    assign pmode_a = pm[0];
    assign pmode_b = pm[1];
endmodule

// File: rtl/dac_serial_rx_chk.sv
// Property checker for the serial dual-DAC command receiver, bound to the top.
module dac_serial_rx_chk #(
    parameter int DATA_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frm_valid,
    input logic [DATA_W+3:0]   frm_word,
    input logic                ld_s,
    input logic                ld_pulse,
    input logic [DATA_W-1:0]   dac_a,
    input logic [DATA_W-1:0]   dac_b,
    input logic [1:0]          buf_en,
    input logic [1:0]          pmode_a,
    input logic [1:0]          pmode_b
);
    localparam int FW = DATA_W + 4;

    // R1: reset clears every output.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dac_a == '0 && dac_b == '0 && buf_en == 2'b00 &&
                    pmode_a == 2'b00 && pmode_b == 2'b00));

    // R6: with load low, a channel A frame reaches its code next cycle.
    a_r6_auto_update: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_word[FW-1] && !ld_s |=>
            dac_a == $past(frm_word[DATA_W-1:0]));

    // R7/R8: a code moves only after a completed frame or a load edge.
    a_r7_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_b) |-> $past(frm_valid || ld_pulse));

    // R4/R5: controls of channel A follow its frame.
    a_r5_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_word[FW-1] |=>
            pmode_a == $past(frm_word[FW-3:FW-4]) &&
            buf_en[0] == $past(frm_word[FW-2]));

    // R3: a channel A frame leaves channel B controls alone.
    a_r3_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_word[FW-1] |=> $stable(pmode_b) && $stable(buf_en[1]));
endmodule

bind dac_serial_rx dac_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_word  (frm_word),
    .ld_s      (ld_s),
    .ld_pulse  (ld_pulse),
    .dac_a     (dac_a),
    .dac_b     (dac_b),
    .buf_en    (buf_en),
    .pmode_a   (pmode_a),
    .pmode_b   (pmode_b)
);

// File: tb/dac_serial_rx_bench.sv
module dac_serial_rx_bench;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sclk, din, sync_n, ld;
    logic [DW-1:0] dac_a, dac_b;
    logic [1:0]    buf_en, pmode_a, pmode_b;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [DW-1:0] exp_inp [2];
    logic [DW-1:0] exp_dac [2];
    logic [1:0]    exp_pm  [2];
    logic [1:0]    exp_buf;

    always #10 clk = ~clk;

    dac_serial_rx #(.DATA_W(DW)) u_dac_serial_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
        .ld(ld), .dac_a(dac_a), .dac_b(dac_b), .buf_en(buf_en),
        .pmode_a(pmode_a), .pmode_b(pmode_b)
    );

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " dac_a"}, dac_a, exp_dac[0]);
        check({tag, " dac_b"}, dac_b, exp_dac[1]);
        check("R4 buf_en", DW'(buf_en), DW'(exp_buf));
        check("R5 pmode_a", DW'(pmode_a), DW'(exp_pm[0]));
        check("R5 pmode_b", DW'(pmode_b), DW'(exp_pm[1]));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits, MSB first from bits[n-1]; sync_n rises afterwards.
    task automatic send_bits(input logic [31:0] bits, input int n);
        sync_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            din = bits[n-1-i];
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
        end
        wait_clk(4);
        sync_n = 1'b1;
        wait_clk(8);
    endtask

    // Reference model of a completed frame (R3..R7).
    task automatic model_frame(input logic [15:0] w);
        int ch = int'(w[15]);
        exp_buf[ch] = w[14];
        exp_pm[ch]  = w[13:12];
        exp_inp[ch] = w[11:0];
        if (!ld) exp_dac[ch] = w[11:0];
    endtask

    task automatic frame(input logic [15:0] w);
        send_bits({16'h0, w}, 16);
        model_frame(w);
    endtask

    task automatic raise_ld;
        ld = 1'b1;
        wait_clk(8);
        exp_dac[0] = exp_inp[0];
        exp_dac[1] = exp_inp[1];
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            exp_inp[i] = '0; exp_dac[i] = '0; exp_pm[i] = 2'b00;
        end
        exp_buf = 2'b00;
        rst_n = 1'b0; sclk = 1'b1; din = 1'b0; sync_n = 1'b1; ld = 1'b0;
        wait_clk(6);
        check_all("R1 reset");
        rst_n = 1'b1;
        wait_clk(6);

        // R9: aborted frame changes nothing; R1 outputs still zero.
        send_bits({16'h0, 16'hFFFF}, 10);
        check_all("R9 R1 abort");

        // R2 R3 R6: sweep every control header with several codes.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 3; p++) begin
                logic [DW-1:0] d;
                d = (p == 0) ? 12'h000 : (p == 1) ? 12'hFFF
                    : (DW'(c) * 12'h111) ^ 12'h5A3;
                frame({4'(c), d});
                check_all("R2 R3 R6 sweep");
            end
        end

        // R9: abort after 15 bits, then a fresh frame must decode cleanly.
        send_bits({16'h0, 16'h2ABC}, 15);
        check_all("R9 abort15");
        frame(16'h1357);
        check_all("R9 fresh");

        // R10: extra edges after the 16th bit do not re-commit.
        send_bits({12'h0, 16'hB6C9, 4'hF}, 20);
        model_frame(16'hB6C9);
        check_all("R10 extra edges");

        // R7: load high, frames only reach the input registers.
        raise_ld();
        check_all("R8 load idle");
        frame(16'h0ACE);
        frame(16'hF123);
        check_all("R7 held");

        // R8: lower then raise load, both codes update together.
        ld = 1'b0;
        wait_clk(8);
        check_all("R7 ld fall no update");
        raise_ld();
        check_all("R8 load both");

        // R7 again on channel B only, then load.
        frame(16'h8765);
        check_all("R7 held b");
        ld = 1'b0;
        wait_clk(8);
        raise_ld();
        check_all("R8 load b");
        ld = 1'b0;
        wait_clk(8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule